// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a small binary up-counter, four bits wide by default. It advances on the rising clock edge and can be preset from a parallel data bus. Two active-high enables gate counting. The first enable gates only the increment. The second also gates the terminal-count output. Because of this, several stages can be chained into a wider synchronous counter with no ripple between stages: each stage's terminal count feeds the second enable of the next stage.

An active-low master reset clears the count. A build-time parameter chooses between two reset variants:
- Asynchronous: the count clears at once.
- Synchronous: the count clears at the next rising edge.

Loading uses an active-low strobe sampled at the clock edge. At an edge, reset takes priority over load, load over count, and count over hold.

Top module: `presettable_counter`

## Requirements
- R1: The count changes only at a rising clock edge; moving the load, data or enable inputs between edges leaves the count unchanged.
- R2: With the master reset low, the count reads 0 and terminal count reads 0, whatever the load, data and enable inputs are.
- R3: With ASYNC_RESET=1 the count clears as soon as reset goes low, with no clock edge. With ASYNC_RESET=0 it keeps its value until the next rising edge, then clears.
- R4: A low on the load strobe at a rising edge copies the data bus into the count, whatever the two enables are.
- R5: With load high and both enables high, each rising edge adds one to the count.
- R6: With load high and either enable low, the count holds its value across the edge.
- R7: Counting from the all-ones value gives zero at the next edge.
- R8: Terminal count is high exactly when the second (chain) enable is high and the count is all ones; the first (count) enable has no effect on it.
- R9: Two stages form an 8-bit counter when the lower stage's terminal count drives the upper stage's chain enable. The upper stage advances once for every 16 counts of the lower stage.
- R10: At an edge, reset wins over load, and load wins over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Master reset, active low |
| loadN | input | 1 | Parallel load strobe, active low, sampled at the edge |
| data | input | WIDTH | Value copied into the count on load |
| cntEn | input | 1 | Count enable that gates only the increment |
| chainEn | input | 1 | Chain enable that gates both the increment and terminal count |
| count | output | WIDTH | Present count |
| termCount | output | 1 | High when chainEn is high and count is all ones |

## Verification
The bench builds three configurations of the block.
- A 4-bit stage with asynchronous reset and a 4-bit stage with synchronous reset receive identical stimulus. A reset dropped between edges therefore shows the two reset timings side by side.
- Two synchronous-reset stages are chained into an 8-bit counter and checked against a reference count every cycle. This brings the carry across the stage boundary, a pause of the shared enable, and a load of both stages within reach.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;
  // Decoded actions for one clock edge, from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } cntStrobe_t;
endpackage

// File: rtl/cnt_ctrl.sv
`timescale 1ns/1ps
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic       loadN,
  input  logic       cntEn,
  input  logic       chainEn,
  output cntStrobe_t strobe
);
  // Load overrides counting; counting needs both enables
  always_comb begin
    strobe.load = ~loadN;
    strobe.step = loadN & cntEn & chainEn;
  end
endmodule

// File: rtl/cnt_datapath.sv
`timescale 1ns/1ps
module cnt_datapath
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [WIDTH-1:0] data,
  input  logic             chainEn,
  output logic [WIDTH-1:0] count,
  output logic             termCount
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countNext;

  always_comb begin
    if (strobe.load)      countNext = data;
    else if (strobe.step) countNext = countQ + ONE;
    else                  countNext = countQ;
  end

  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) countQ <= '0;
        else       countQ <= countNext;
      end
      // R3
      async_clear_chk: assert property (@(posedge clk) !rstN |-> countQ == '0);
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) countQ <= '0;
        else       countQ <= countNext;
      end
      // R3
      sync_clear_chk: assert property (@(posedge clk) !rstN |=> countQ == '0);
    end
  endgenerate

  assign count     = countQ;
  assign termCount = chainEn & (countQ == ALL_ONES);

  // R4
  load_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> countQ == $past(data));
  // R5
  step_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && strobe.step) |=> countQ == $past(countQ) + ONE);
  // R6
  hold_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(countQ));
endmodule

// File: rtl/presettable_counter.sv
`timescale 1ns/1ps
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] data,
  input  logic             cntEn,
  input  logic             chainEn,
  output logic [WIDTH-1:0] count,
  output logic             termCount
);
  cntStrobe_t strobe;

  cnt_ctrl uCtrl (
    .loadN   (loadN),
    .cntEn   (cntEn),
    .chainEn (chainEn),
    .strobe  (strobe)
  );

  cnt_datapath #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .data      (data),
    .chainEn   (chainEn),
    .count     (count),
    .termCount (termCount)
  );

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (termCount && cntEn && loadN) |=> count == '0);
endmodule

// File: tb/sim_presettable_counter.sv
`timescale 1ns/1ps
module sim_presettable_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       rstN, loadN, cntEn, chainEn;
  logic [3:0] data;
  logic [3:0] count, syncCount;
  logic       termCount, syncTc;

  logic       cLoadN, cEn;
  logic [7:0] cData;
  logic [3:0] loCount, hiCount;
  logic       loTc, hiTc;

  int testsRun  = 0;
  int testsFail = 0;
  bit done      = 1'b0;

  presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .loadN(loadN), .data(data), .cntEn(cntEn),
    .chainEn(chainEn), .count(count), .termCount(termCount));

  presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) uSync (
    .clk(clk), .rstN(rstN), .loadN(loadN), .data(data), .cntEn(cntEn),
    .chainEn(chainEn), .count(syncCount), .termCount(syncTc));

  presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) uLo (
    .clk(clk), .rstN(rstN), .loadN(cLoadN), .data(cData[3:0]), .cntEn(cEn),
    .chainEn(cEn), .count(loCount), .termCount(loTc));

  presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) uHi (
    .clk(clk), .rstN(rstN), .loadN(cLoadN), .data(cData[7:4]), .cntEn(cEn),
    .chainEn(loTc), .count(hiCount), .termCount(hiTc));

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // {req[3:0], loadN, cntEn, chainEn, data[3:0], expCount[3:0], expTc}
  localparam int NVEC = 13;
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd4,  1'b0, 1'b0, 1'b0, 4'd12, 4'd12, 1'b0},  // R4 load with enables low
    {4'd5,  1'b1, 1'b1, 1'b1, 4'd0,  4'd13, 1'b0},  // R5
    {4'd5,  1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0},
    {4'd8,  1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1},  // R8 all ones, chain high
    {4'd7,  1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R7 wrap
    {4'd5,  1'b1, 1'b1, 1'b1, 4'd0,  4'd1,  1'b0},
    {4'd5,  1'b1, 1'b1, 1'b1, 4'd0,  4'd2,  1'b0},
    {4'd6,  1'b1, 1'b0, 1'b1, 4'd0,  4'd2,  1'b0},  // R6 count enable low
    {4'd6,  1'b1, 1'b1, 1'b0, 4'd0,  4'd2,  1'b0},  // R6 chain enable low
    {4'd8,  1'b0, 1'b0, 1'b1, 4'd15, 4'd15, 1'b1},  // R8 tc with count enable low
    {4'd8,  1'b1, 1'b0, 1'b0, 4'd0,  4'd15, 1'b0},  // R8 chain low masks tc
    {4'd10, 1'b0, 1'b1, 1'b1, 4'd5,  4'd5,  1'b0},  // R10 load beats count
    {4'd4,  1'b0, 1'b1, 1'b1, 4'd9,  4'd9,  1'b0}   // R4
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ref8;
    rstN = 1'b0; loadN = 1'b0; data = 4'd6; cntEn = 1'b1; chainEn = 1'b1;
    cLoadN = 1'b1; cEn = 1'b0; cData = 8'h00;
    repeat (3) @(posedge clk);
    #5;
    // R2 reset state with load asserted and enables high
    check("R2 count", int'(count), 0);
    check("R2 tc", int'(termCount), 0);
    check("R2 sync count", int'(syncCount), 0);
    check("R2 cascade", int'({hiCount, loCount}), 0);
    rstN = 1'b1; loadN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      loadN   = VEC[i][11];
      cntEn   = VEC[i][10];
      chainEn = VEC[i][9];
      data    = VEC[i][8:5];
      @(posedge clk);
      #5;
      check($sformatf("R%0d count vec %0d", VEC[i][15:12], i), int'(count), int'(VEC[i][4:1]));
      check($sformatf("R%0d tc vec %0d", VEC[i][15:12], i), int'(termCount), int'(VEC[i][0]));
      check($sformatf("R%0d sync count vec %0d", VEC[i][15:12], i), int'(syncCount), int'(VEC[i][4:1]));
    end

    // R1: inputs move between edges, count stays
    loadN = 1'b0; data = 4'd3;
    #5;
    check("R1 no edge", int'(count), 9);
    loadN = 1'b1; cntEn = 1'b0; chainEn = 1'b0;
    @(posedge clk);
    #5;
    check("R1 hold after edge", int'(count), 9);

    // R3 and R10: reset mid-cycle while loading with enables high
    loadN = 1'b0; data = 4'd7; cntEn = 1'b1; chainEn = 1'b1; rstN = 1'b0;
    #2;
    check("R3 async clears at once", int'(count), 0);
    check("R3 sync waits for edge", int'(syncCount), 9);
    @(posedge clk);
    #5;
    check("R3 sync cleared at edge", int'(syncCount), 0);
    check("R10 reset beats load", int'(count), 0);
    check("R2 tc low in reset", int'(syncTc), 0);
    rstN = 1'b1; loadN = 1'b1; cntEn = 1'b0; chainEn = 1'b0;

    // R9: 8-bit cascade against a reference count
    ref8 = 8'h00;
    for (int i = 0; i < 320; i++) begin
      cLoadN = !(i == 0 || i == 200);
      cData  = (i == 0) ? 8'hF0 : 8'hFE;
      cEn    = !(i >= 100 && i < 105);
      if (!cLoadN) ref8 = cData;
      else if (cEn) ref8 = ref8 + 8'd1;
      @(posedge clk);
      #5;
      check($sformatf("R9 cascade step %0d", i), int'({hiCount, loCount}), int'(ref8));
    end
    cEn = 1'b0; cLoadN = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule